// File: doc/BRIEF.md
# Exception Entry Controller

This block performs exception entry for a 32-bit RISC core that has branch delay slots. Each cycle the core may present one exception request: a 4-bit cause code, the effective address of the fault, the current program counter, a flag telling whether the faulting instruction occupies a delay slot, and a debug-ignore flag. When the request is accepted, the block produces a one-cycle redirect pulse that carries the handler vector. On the same clock edge it records the fault address, saves a copy of the status word, computes the return PC according to the cause class, and switches the status word into supervisor entry state.

The controller owns the status register. The core can write that register through a plain write port whenever no exception is being taken. The vector is the cause code shifted left by eight bits. When the status word's high-vector bit is set, the high base 0xF0000000 is added to that offset. Choosing one request among several simultaneous faults is done before this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: For an accepted request with status bit 14 (high-vector select) clear, `redir_pc` equals the cause code shifted left by 8.
- R2: For an accepted request with status bit 14 set, `redir_pc` equals 0xF0000000 plus the cause code shifted left by 8.
- R3: On entry, `fault_addr_q` takes the incoming effective address and `saved_sr_q` takes the status word as it was before entry.
- R4: On entry, the status word sets bit 0 (supervisor) and clears bit 1 (tick enable), bit 2 (interrupt enable), bit 5 (data MMU enable), bit 6 (instruction MMU enable) and bit 12 (overflow-exception enable). All other bits, bit 14 included, are kept.
- R5: Cause code 1 (reset) leaves `ret_pc_q` unchanged.
- R6: For codes 2, 3, 4, 6, 7, 9, 10, 11, 13 and 14 (synchronous faults), `ret_pc_q` is the PC, minus 4 when the delay-slot flag is set.
- R7: For code 12 (system call), `ret_pc_q` is the PC plus 4, minus 4 when the delay-slot flag is set.
- R8: For code 5 (tick) and code 8 (external interrupt), `ret_pc_q` is the PC, which already points at the next unexecuted instruction, minus 4 when the delay-slot flag is set.
- R9: `clr_dslot` pulses together with `redir_valid`, so the core drops its delay-slot state before the first handler instruction.
- R10: When `dbg_ignore` is high, the request causes no redirect and changes none of the status, saved-status, fault-address or return-PC registers.
- R11: Code 0 and code 15 are no request: no redirect and no register change.
- R12: `redir_valid` is high for exactly one cycle per accepted request, in the cycle after the request. All register updates appear at that same edge.
- R13: `sr_we` loads `sr_wdata` into the status word one cycle later when no request is accepted in that cycle. An accepted request takes precedence over a simultaneous write.
- R14: After reset, `redir_valid` and `clr_dslot` are 0, the status word equals 0x00000001, and the saved-status, fault-address and return-PC registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_code | input | 4 | Cause code; 0 and 15 mean no request |
| exc_ea | input | 32 | Effective address of the fault |
| exc_pc | input | 32 | Current program counter |
| exc_in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| dbg_ignore | input | 1 | Debug logic asks to drop this request |
| sr_we | input | 1 | Status word write strobe |
| sr_wdata | input | 32 | Status word write data |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Handler vector address |
| clr_dslot | output | 1 | Clear the core's delay-slot state |
| sr_q | output | 32 | Current status word |
| saved_sr_q | output | 32 | Status word saved at entry |
| fault_addr_q | output | 32 | Effective address saved at entry |
| ret_pc_q | output | 32 | Return PC saved at entry |

## Verification
The bench targets the delay-slot adjustment for each return-PC class. A design that picks the wrong class, for example treating a system call like a fault, returns into the trapping instruction and loops forever. It also covers the reset code: a design that rewrites the return PC there would corrupt a saved context. It checks that high-vector selection adds the high base and keeps bit 14 set across entry. Finally, it checks that debug-ignored requests, no-request codes and a status write issued in the same cycle as an exception leave exactly the state the requirements call for. A design that lets the write win would re-enable interrupts inside the handler.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [2:0] {
      CLS_NONE    = 3'd0,
      CLS_RESET   = 3'd1,
      CLS_SYNC    = 3'd2,
      CLS_SYSCALL = 3'd3,
      CLS_ASYNC   = 3'd4
   } exc_class_e;

   localparam int EC_RESET   = 1;
   localparam int EC_BUSERR  = 2;
   localparam int EC_DPF     = 3;
   localparam int EC_IPF     = 4;
   localparam int EC_TICK    = 5;
   localparam int EC_ALIGN   = 6;
   localparam int EC_ILLEGAL = 7;
   localparam int EC_EXTINT  = 8;
   localparam int EC_DTLB    = 9;
   localparam int EC_ITLB    = 10;
   localparam int EC_RANGE   = 11;
   localparam int EC_SYSCALL = 12;
   localparam int EC_FPU     = 13;
   localparam int EC_TRAP    = 14;
   localparam int EC_MAX     = EC_TRAP;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
   import exc_entry_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic              valid,
   output exc_class_e        cls
);

   generate
      if (CODE_W < 4) begin : g_bad_code_w
         $error("exc_classify: CODE_W must hold codes up to 14");
      end
   endgenerate

   always_comb begin
      unique case (int'(code))
         EC_RESET:                                  cls = CLS_RESET;
         EC_BUSERR, EC_DPF, EC_IPF, EC_ALIGN,
         EC_ILLEGAL, EC_DTLB, EC_ITLB, EC_RANGE,
         EC_FPU, EC_TRAP:                           cls = CLS_SYNC;
         EC_SYSCALL:                                cls = CLS_SYSCALL;
         EC_TICK, EC_EXTINT:                        cls = CLS_ASYNC;
         default:                                   cls = CLS_NONE;
      endcase
      valid = (cls != CLS_NONE);
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
   parameter int          ADDR_W    = 32,
   parameter int          CODE_W    = 4,
   parameter int          VEC_SHIFT = 8,
   parameter bit          HIGH_EN   = 1'b1,
   parameter logic [31:0] HIGH_BASE = 32'hF000_0000
) (
   input  logic [CODE_W-1:0] code,
   input  logic              high_sel,
   output logic [ADDR_W-1:0] vec
);

   localparam int OFS_TOP = VEC_SHIFT + CODE_W;

   logic [ADDR_W-1:0] offset;

   generate
      if (OFS_TOP > ADDR_W) begin : g_bad_shift
         $error("exc_vector_gen: shifted code does not fit in ADDR_W");
      end
      if (ADDR_W != 32) begin : g_bad_addr
         $error("exc_vector_gen: ADDR_W must be 32 to match HIGH_BASE");
      end
   endgenerate

   assign offset = ADDR_W'(code) << VEC_SHIFT;

   generate
      if (HIGH_EN) begin : g_high_vec
         assign vec = high_sel ? (offset + HIGH_BASE) : offset;
      end else begin : g_low_only
         logic unused_sel;
         assign unused_sel = high_sel;
         assign vec        = offset;
      end
   endgenerate

endmodule

// File: rtl/exc_retpc_calc.sv
module exc_retpc_calc
   import exc_entry_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INSN_BYTES = 4
) (
   input  exc_class_e        cls,
   input  logic [ADDR_W-1:0] pc,
   input  logic              in_dslot,
   input  logic [ADDR_W-1:0] cur_ret,
   output logic [ADDR_W-1:0] next_ret
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

   logic [ADDR_W-1:0] ds_back;

   generate
      if (INSN_BYTES < 1) begin : g_bad_step
         $error("exc_retpc_calc: INSN_BYTES must be positive");
      end
   endgenerate

   assign ds_back = in_dslot ? STEP : '0;

   always_comb begin
      unique case (cls)
         CLS_SYNC:    next_ret = pc - ds_back;
         CLS_SYSCALL: next_ret = pc + STEP - ds_back;
         CLS_ASYNC:   next_ret = pc - ds_back;
         default:     next_ret = cur_ret;
      endcase
   end

endmodule

// File: rtl/exc_sr_next.sv
module exc_sr_next #(
   parameter int SR_W    = 32,
   parameter int SM_BIT  = 0,
   parameter int TEE_BIT = 1,
   parameter int IEE_BIT = 2,
   parameter int DME_BIT = 5,
   parameter int IME_BIT = 6,
   parameter int OVE_BIT = 12
) (
   input  logic [SR_W-1:0] sr_cur,
   output logic [SR_W-1:0] sr_entry
);

   localparam int NCLR = 5;
   localparam int CLR_POS [NCLR] = '{TEE_BIT, IEE_BIT, DME_BIT, IME_BIT, OVE_BIT};

   logic [SR_W-1:0] clr_mask;
   logic [SR_W-1:0] set_mask;

   generate
      if (SM_BIT >= SR_W) begin : g_bad_sm
         $error("exc_sr_next: SM_BIT out of range");
      end
      for (genvar b = 0; b < SR_W; b++) begin : g_mask
         logic hit;
         always_comb begin
            hit = 1'b0;
            for (int k = 0; k < NCLR; k++) begin
               if (CLR_POS[k] == b) hit = 1'b1;
            end
         end
         assign clr_mask[b] = hit;
         assign set_mask[b] = (b == SM_BIT);
      end
   endgenerate

   assign sr_entry = (sr_cur & ~clr_mask) | set_mask;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          CODE_W     = 4,
   parameter int          SR_W       = 32,
   parameter int          VEC_SHIFT  = 8,
   parameter int          INSN_BYTES = 4,
   parameter bit          HIGH_EN    = 1'b1,
   parameter logic [31:0] HIGH_BASE  = 32'hF000_0000,
   parameter logic [31:0] SR_RESET   = 32'h0000_0001,
   parameter int          SM_BIT     = 0,
   parameter int          TEE_BIT    = 1,
   parameter int          IEE_BIT    = 2,
   parameter int          DME_BIT    = 5,
   parameter int          IME_BIT    = 6,
   parameter int          OVE_BIT    = 12,
   parameter int          EPH_BIT    = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] exc_code,
   input  logic [ADDR_W-1:0] exc_ea,
   input  logic [ADDR_W-1:0] exc_pc,
   input  logic              exc_in_dslot,
   input  logic              dbg_ignore,
   input  logic              sr_we,
   input  logic [SR_W-1:0]   sr_wdata,
   output logic              redir_valid,
   output logic [ADDR_W-1:0] redir_pc,
   output logic              clr_dslot,
   output logic [SR_W-1:0]   sr_q,
   output logic [SR_W-1:0]   saved_sr_q,
   output logic [ADDR_W-1:0] fault_addr_q,
   output logic [ADDR_W-1:0] ret_pc_q
);

   generate
      if (EPH_BIT >= SR_W || OVE_BIT >= SR_W || IME_BIT >= SR_W) begin : g_bad_sr
         $error("exc_entry_ctrl: status bit position outside SR_W");
      end
   endgenerate

   logic              req_valid;
   exc_class_e        req_cls;
   logic              accept;
   logic [ADDR_W-1:0] vec;
   logic [ADDR_W-1:0] ret_next;
   logic [SR_W-1:0]   sr_entry;

   exc_classify #(.CODE_W(CODE_W)) i_classify (
      .code  (exc_code),
      .valid (req_valid),
      .cls   (req_cls)
   );

   exc_vector_gen #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .VEC_SHIFT(VEC_SHIFT),
      .HIGH_EN(HIGH_EN), .HIGH_BASE(HIGH_BASE)
   ) i_vector (
      .code     (exc_code),
      .high_sel (sr_q[EPH_BIT]),
      .vec      (vec)
   );

   exc_retpc_calc #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) i_retpc (
      .cls      (req_cls),
      .pc       (exc_pc),
      .in_dslot (exc_in_dslot),
      .cur_ret  (ret_pc_q),
      .next_ret (ret_next)
   );

   exc_sr_next #(
      .SR_W(SR_W), .SM_BIT(SM_BIT), .TEE_BIT(TEE_BIT), .IEE_BIT(IEE_BIT),
      .DME_BIT(DME_BIT), .IME_BIT(IME_BIT), .OVE_BIT(OVE_BIT)
   ) i_sr_next (
      .sr_cur   (sr_q),
      .sr_entry (sr_entry)
   );

   assign accept = req_valid && !dbg_ignore;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redir_valid  <= 1'b0;
         clr_dslot    <= 1'b0;
         redir_pc     <= '0;
         sr_q         <= SR_W'(SR_RESET);
         saved_sr_q   <= '0;
         fault_addr_q <= '0;
         ret_pc_q     <= '0;
      end else begin
         redir_valid <= accept;
         clr_dslot   <= accept;
         if (accept) begin
            redir_pc     <= vec;
            sr_q         <= sr_entry;
            saved_sr_q   <= sr_q;
            fault_addr_q <= exc_ea;
            ret_pc_q     <= ret_next;
         end else if (sr_we) begin
            sr_q <= sr_wdata;
         end
      end
   end

   AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (redir_pc[VEC_SHIFT-1:0] == '0)); // R1

   AST_VEC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> ((redir_pc[ADDR_W-1 -: 4] == 4'hF) == (HIGH_EN && saved_sr_q[EPH_BIT]))); // R2

   AST_SAVED_SR: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (saved_sr_q == $past(sr_q))); // R3

   AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (fault_addr_q == $past(exc_ea))); // R3

   AST_SUPV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (sr_q[SM_BIT] && !sr_q[TEE_BIT] && !sr_q[IEE_BIT] &&
                       !sr_q[DME_BIT] && !sr_q[IME_BIT] && !sr_q[OVE_BIT])); // R4

   AST_EPH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (sr_q[EPH_BIT] == $past(sr_q[EPH_BIT]))); // R4

   AST_RESET_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(exc_code) == EC_RESET) |=> $stable(ret_pc_q)); // R5

   AST_DSLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> clr_dslot); // R9

   AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_ignore |=> (!redir_valid && $stable(fault_addr_q) && $stable(ret_pc_q))); // R10

   AST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_code == '0 || int'(exc_code) > EC_MAX) |=> !redir_valid); // R11

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !redir_valid |-> ($stable(saved_sr_q) && $stable(fault_addr_q))); // R12

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;
   localparam logic [31:0] SR_BASE  = 32'h0000_1066;
   localparam logic [31:0] CLR_MASK = 32'h0000_1066;

   // {code[3:0], dslot, high, pc[31:0], ea[31:0]}
   localparam logic [69:0] TBL [NVEC] = '{
      {4'd2,  1'b0, 1'b0, 32'h0000_1000, 32'hDEAD_0004},
      {4'd3,  1'b1, 1'b0, 32'h0000_2008, 32'h1234_5678},
      {4'd4,  1'b0, 1'b1, 32'h0000_3000, 32'h0000_3000},
      {4'd5,  1'b1, 1'b0, 32'h0000_4010, 32'h0000_0000},
      {4'd8,  1'b0, 1'b0, 32'h0000_5004, 32'h0000_0011},
      {4'd12, 1'b0, 1'b0, 32'h0000_6000, 32'h0000_0022},
      {4'd12, 1'b1, 1'b1, 32'h0000_6104, 32'h0000_0033},
      {4'd1,  1'b0, 1'b0, 32'h0000_0100, 32'h0000_00AA},
      {4'd14, 1'b1, 1'b0, 32'h0000_7000, 32'h0000_0055},
      {4'd10, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_8000},
      {4'd6,  1'b1, 1'b1, 32'h0000_9200, 32'h0000_9203},
      {4'd13, 1'b0, 1'b0, 32'h0000_A000, 32'h0000_0066}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  exc_code = '0;
   logic [31:0] exc_ea = '0;
   logic [31:0] exc_pc = '0;
   logic        exc_in_dslot = 1'b0;
   logic        dbg_ignore = 1'b0;
   logic        sr_we = 1'b0;
   logic [31:0] sr_wdata = '0;
   logic        redir_valid;
   logic [31:0] redir_pc;
   logic        clr_dslot;
   logic [31:0] sr_q;
   logic [31:0] saved_sr_q;
   logic [31:0] fault_addr_q;
   logic [31:0] ret_pc_q;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_ctrl i_exc_entry_ctrl (
      .clk, .rst_n, .exc_code, .exc_ea, .exc_pc, .exc_in_dslot, .dbg_ignore,
      .sr_we, .sr_wdata, .redir_valid, .redir_pc, .clr_dslot, .sr_q,
      .saved_sr_q, .fault_addr_q, .ret_pc_q
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      exc_code = '0; exc_ea = '0; exc_pc = '0; exc_in_dslot = 1'b0;
      dbg_ignore = 1'b0; sr_we = 1'b0; sr_wdata = '0;
   endtask

   task automatic write_sr(input logic [31:0] val);
      @(negedge clk);
      sr_we = 1'b1; sr_wdata = val;
      @(posedge clk); #1;
      check("R13 status write", sr_q, val);
      @(negedge clk);
      idle_inputs();
   endtask

   function automatic logic [31:0] exp_ret(input logic [3:0] code, input logic ds,
                                           input logic [31:0] pc, input logic [31:0] prev);
      logic [31:0] back;
      back = ds ? 32'd4 : 32'd0;
      if (code == 4'd1) return prev;
      if (code == 4'd12) return pc + 32'd4 - back;
      return pc - back;
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      check("R14 redir_valid after reset", {31'b0, redir_valid}, 32'd0);
      check("R14 clr_dslot after reset", {31'b0, clr_dslot}, 32'd0);
      check("R14 status after reset", sr_q, 32'h0000_0001);
      check("R14 saved status after reset", saved_sr_q, 32'd0);
      check("R14 fault addr after reset", fault_addr_q, 32'd0);
      check("R14 return pc after reset", ret_pc_q, 32'd0);

      // vector table: R1 R2 R3 R4 R5 R6 R7 R8 R9 R12
      for (int i = 0; i < NVEC; i++) begin
         logic [3:0]  code;
         logic        ds;
         logic        hi;
         logic [31:0] pc;
         logic [31:0] ea;
         logic [31:0] sr0;
         logic [31:0] prev_ret;
         logic [31:0] vec;
         {code, ds, hi, pc, ea} = TBL[i];
         sr0 = SR_BASE | (hi ? 32'h0000_4000 : 32'h0);
         write_sr(sr0);
         prev_ret = ret_pc_q;
         vec = ({28'b0, code} << 8) + (hi ? 32'hF000_0000 : 32'h0);
         exc_code = code; exc_pc = pc; exc_ea = ea; exc_in_dslot = ds;
         @(posedge clk); #1;
         check("R12 redirect pulse", {31'b0, redir_valid}, 32'd1);
         check(hi ? "R2 high vector" : "R1 low vector", redir_pc, vec);
         check("R9 clear delay slot", {31'b0, clr_dslot}, 32'd1);
         check("R3 saved status", saved_sr_q, sr0);
         check("R3 fault address", fault_addr_q, ea);
         check("R4 entry status", sr_q, (sr0 & ~CLR_MASK) | 32'h1);
         if (code == 4'd1)
            check("R5 reset keeps return pc", ret_pc_q, prev_ret);
         else if (code == 4'd12)
            check("R7 syscall return pc", ret_pc_q, exp_ret(code, ds, pc, prev_ret));
         else if (code == 4'd5 || code == 4'd8)
            check("R8 async return pc", ret_pc_q, exp_ret(code, ds, pc, prev_ret));
         else
            check("R6 fault return pc", ret_pc_q, exp_ret(code, ds, pc, prev_ret));
         @(negedge clk);
         idle_inputs();
         @(posedge clk); #1;
         check("R12 pulse ends", {31'b0, redir_valid}, 32'd0);
      end

      // R10: debug ignore
      begin
         logic [31:0] s0, ss0, fa0, rp0;
         write_sr(SR_BASE);
         s0 = sr_q; ss0 = saved_sr_q; fa0 = fault_addr_q; rp0 = ret_pc_q;
         @(negedge clk);
         exc_code = 4'd2; exc_pc = 32'h0000_C000; exc_ea = 32'hCAFE_0000; dbg_ignore = 1'b1;
         @(posedge clk); #1;
         check("R10 ignore no redirect", {31'b0, redir_valid}, 32'd0);
         check("R10 ignore status", sr_q, s0);
         check("R10 ignore saved status", saved_sr_q, ss0);
         check("R10 ignore fault addr", fault_addr_q, fa0);
         check("R10 ignore return pc", ret_pc_q, rp0);
         @(negedge clk);
         idle_inputs();
      end

      // R11: code 0 and code 15
      for (int c = 0; c < 2; c++) begin
         logic [31:0] s0, fa0, rp0;
         s0 = sr_q; fa0 = fault_addr_q; rp0 = ret_pc_q;
         @(negedge clk);
         exc_code = (c == 0) ? 4'd0 : 4'd15;
         exc_pc = 32'h0000_D000; exc_ea = 32'hBEEF_0000; exc_in_dslot = 1'b1;
         @(posedge clk); #1;
         check("R11 no request redirect", {31'b0, redir_valid}, 32'd0);
         check("R11 no request status", sr_q, s0);
         check("R11 no request fault addr", fault_addr_q, fa0);
         check("R11 no request return pc", ret_pc_q, rp0);
         @(negedge clk);
         idle_inputs();
      end

      // R13: exception beats a simultaneous status write
      write_sr(SR_BASE);
      @(negedge clk);
      exc_code = 4'd7; exc_pc = 32'h0000_E000; exc_ea = 32'h0000_0077;
      sr_we = 1'b1; sr_wdata = 32'hFFFF_FFFF;
      @(posedge clk); #1;
      check("R13 entry wins over write", sr_q, (SR_BASE & ~CLR_MASK) | 32'h1);
      check("R13 saved status is pre-entry", saved_sr_q, SR_BASE);
      check("R6 illegal return pc", ret_pc_q, 32'h0000_E000);
      @(negedge clk);
      idle_inputs();
      @(posedge clk); #1;

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule